// File: doc/BRIEF.md
# Graphics Pixel Colour Mapper

This block turns the pixel codes of a graphics region into display colour. A code of 2, 4 or 8 bits arrives on a valid/ready stream. A small bit-map table can remap it into an index into a 256-entry colour look-up table (CLUT). The selected CLUT entry leaves on a second valid/ready stream as luma Y, chroma U and V, and a 6-bit transparency T, one clock after the pixel is accepted. The bit-map tables let a low-depth code reach any chosen subset of the large CLUT. A 2-bit code can use a 4-entry table that holds 4-bit CLUT indices, or a 4-entry table that holds 8-bit indices. A 4-bit code uses a 16-entry table that holds 8-bit indices. An 8-bit code addresses the CLUT directly.

A host loads the CLUT, the three bit-map tables and a mode register through a write-request port. A write completes only in a cycle where no pixel is handed over. Otherwise it waits. Between display lines, when the pixel stream is idle, the host can therefore reload every CLUT entry at one entry per clock.

Back-pressure rules: `pix_ready` is high whenever the output register is empty or the consumer takes the current output in the same cycle. While `out_valid` is high and `out_ready` is low, the output word and `out_valid` do not change, and no new pixel is accepted. A producer keeps `pix_valid` and `pix_code` steady until a handshake occurs.

Top module: `gclut_pixel_map`

## Requirements
- R1: After reset, `out_valid` is 0, `pix_ready` is 1, the mode register is 0 (direct 8-bit), and every CLUT and bit-map table entry reads as zero.
- R2: In mode 0, the 8-bit code is the CLUT index. The output carries that entry's Y, U, V and T, with the entry stored as cfg_wdata bits [29:22]=Y, [21:14]=U, [13:6]=V and [5:0]=T.
- R3: In mode 1 (2-bit, small table), code bits [1:0] select one of 4 table-A entries. Each table-A entry is 4 bits wide and addresses CLUT entries 0..15. Code bits [7:2] are ignored.
- R4: In mode 2 (2-bit, wide table), code bits [1:0] select one of 4 table-B entries. Each table-B entry holds a full 8-bit CLUT index. Code bits [7:2] are ignored.
- R5: In mode 3 (4-bit), code bits [3:0] select one of 16 table-C entries. Each table-C entry holds an 8-bit CLUT index. Code bits [7:4] are ignored.
- R6: In modes 4 to 7, which have no valid mapping, every output field is zero, so the pixel is fully transparent (T=0).
- R7: A pixel accepted at a clock edge (pix_valid and pix_ready both high) shows `out_valid` high after that edge.
- R8: `pix_ready` equals `!out_valid || out_ready`. While `out_valid` is high and `out_ready` is low, `out_valid` and the Y/U/V/T outputs hold steady. Outputs leave in acceptance order.
- R9: `cfg_wr_ack` is high exactly when `cfg_wr_req` is high and no pixel handshake takes place in that cycle. The write takes effect at that edge, and the host holds the request until it is acknowledged.
- R10: Write targets are selected by cfg_sel. Value 0 is the CLUT, using addr[7:0] and data[29:0]. Value 1 is table A, using addr[1:0] and data[3:0]. Value 2 is table B, using addr[1:0] and data[7:0]. Value 3 is table C, using addr[3:0] and data[7:0]. Value 4 is the mode register, using data[2:0]. Values 5 to 7 are acknowledged and change nothing.
- R11: With the pixel stream idle, consecutive write requests are acknowledged in consecutive cycles, so 256 CLUT entries load in 256 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_valid | input | 1 | Input pixel valid |
| pix_ready | output | 1 | Block can accept a pixel |
| pix_code | input | 8 | Pixel code |
| out_valid | output | 1 | Output colour valid |
| out_ready | input | 1 | Consumer accepts the output |
| out_y | output | 8 | Luma |
| out_u | output | 8 | Chroma U |
| out_v | output | 8 | Chroma V |
| out_t | output | 6 | Transparency, 0 = fully transparent |
| cfg_wr_req | input | 1 | Host write request |
| cfg_wr_ack | output | 1 | Write performed this cycle |
| cfg_sel | input | 3 | Write target select |
| cfg_addr | input | 8 | Entry address within the target |
| cfg_wdata | input | 30 | Write data |

## Verification
The bench sets the unused high bits of every low-depth code, so a design that indexed a table with the wrong slice would show the wrong colour. It puts table-A entries at 15 and table-B/C entries above 15, so a design that widened the 4-bit table-A indices wrongly, or truncated the 8-bit ones, would land on the wrong CLUT entry. Two invalid modes must give all zeros; a design that fell through to direct mapping would show a coloured pixel. A write request is held against a saturated pixel stream: a design that let the write through would raise `cfg_wr_ack` during a handshake, and one that never retried would leave the write unacknowledged. Random output back-pressure checks that words are neither dropped nor duplicated, and a long stall checks that the held output stays steady.

// File: rtl/gclut_pkg.sv
package gclut_pkg;

  // Pixel-to-index mapping modes held in the mode register.
  typedef enum logic [2:0] {
    MAP_DIRECT8  = 3'd0,
    MAP_2B_NARROW = 3'd1,
    MAP_2B_WIDE  = 3'd2,
    MAP_4B_WIDE  = 3'd3
  } map_mode_e;

  // Targets of a host write.
  typedef enum logic [2:0] {
    TGT_PALETTE = 3'd0,
    TGT_TAB_A   = 3'd1,
    TGT_TAB_B   = 3'd2,
    TGT_TAB_C   = 3'd3,
    TGT_MODE    = 3'd4
  } cfg_target_e;

  localparam int unsigned MODE_W  = 3;
  localparam int unsigned SEL_W   = 3;
  localparam int unsigned TAB_A_N = 4;
  localparam int unsigned TAB_A_W = 4;
  localparam int unsigned TAB_B_N = 4;
  localparam int unsigned TAB_C_N = 16;

endpackage

// File: rtl/gclut_cfg_gate.sv
module gclut_cfg_gate #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 30
) (
  input  logic                      cfg_wr_req,
  input  logic                      pix_fire,
  input  logic [gclut_pkg::SEL_W-1:0] cfg_sel,
  input  logic [AW-1:0]             cfg_addr,
  input  logic [DW-1:0]             cfg_wdata,
  output logic                      cfg_wr_ack,
  output logic                      pal_we,
  output logic                      tab_a_we,
  output logic                      tab_b_we,
  output logic                      tab_c_we,
  output logic                      mode_we,
  output logic [AW-1:0]             wr_addr,
  output logic [DW-1:0]             wr_data
);
  import gclut_pkg::*;

  logic grant;

  // A write may only use a cycle that carries no pixel handshake.
  always_comb begin
    grant    = cfg_wr_req && !pix_fire;
    pal_we   = 1'b0;
    tab_a_we = 1'b0;
    tab_b_we = 1'b0;
    tab_c_we = 1'b0;
    mode_we  = 1'b0;
    if (grant) begin
      unique case (cfg_sel)
        TGT_PALETTE: pal_we   = 1'b1;
        TGT_TAB_A:   tab_a_we = 1'b1;
        TGT_TAB_B:   tab_b_we = 1'b1;
        TGT_TAB_C:   tab_c_we = 1'b1;
        TGT_MODE:    mode_we  = 1'b1;
        default: ;
      endcase
    end
  end

  assign cfg_wr_ack = grant;
  assign wr_addr    = cfg_addr;
  assign wr_data    = cfg_wdata;

endmodule

// File: rtl/gclut_remap.sv
module gclut_remap #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned DW     = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tab_a_we,
  input  logic              tab_b_we,
  input  logic              tab_c_we,
  input  logic              mode_we,
  input  logic [CODE_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [CODE_W-1:0] pix_code,
  output logic [CODE_W-1:0] clut_idx,
  output logic              no_map
);
  import gclut_pkg::*;

  localparam int unsigned A_SEL_W = $clog2(TAB_A_N);
  localparam int unsigned B_SEL_W = $clog2(TAB_B_N);
  localparam int unsigned C_SEL_W = $clog2(TAB_C_N);

  logic [MODE_W-1:0]  mode_q;
  logic [TAB_A_W-1:0] tab_a [TAB_A_N];
  logic [CODE_W-1:0]  tab_b [TAB_B_N];
  logic [CODE_W-1:0]  tab_c [TAB_C_N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_W'(MAP_DIRECT8);
    else if (mode_we) mode_q <= wr_data[MODE_W-1:0];
  end

  for (genvar ia = 0; ia < TAB_A_N; ia++) begin : g_tab_a
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tab_a[ia] <= '0;
      else if (tab_a_we && wr_addr[A_SEL_W-1:0] == A_SEL_W'(ia))
        tab_a[ia] <= wr_data[TAB_A_W-1:0];
    end
  end

  for (genvar ib = 0; ib < TAB_B_N; ib++) begin : g_tab_b
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tab_b[ib] <= '0;
      else if (tab_b_we && wr_addr[B_SEL_W-1:0] == B_SEL_W'(ib))
        tab_b[ib] <= wr_data[CODE_W-1:0];
    end
  end

  for (genvar ic = 0; ic < TAB_C_N; ic++) begin : g_tab_c
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tab_c[ic] <= '0;
      else if (tab_c_we && wr_addr[C_SEL_W-1:0] == C_SEL_W'(ic))
        tab_c[ic] <= wr_data[CODE_W-1:0];
    end
  end

  always_comb begin
    clut_idx = '0;
    no_map   = 1'b0;
    case (mode_q)
      MODE_W'(MAP_DIRECT8):   clut_idx = pix_code;
      MODE_W'(MAP_2B_NARROW): clut_idx = CODE_W'(tab_a[pix_code[A_SEL_W-1:0]]);
      MODE_W'(MAP_2B_WIDE):   clut_idx = tab_b[pix_code[B_SEL_W-1:0]];
      MODE_W'(MAP_4B_WIDE):   clut_idx = tab_c[pix_code[C_SEL_W-1:0]];
      default:                no_map   = 1'b1;
    endcase
  end

endmodule

// File: rtl/gclut_palette.sv
module gclut_palette #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            mem[e] <= '0;
      else if (we && wr_addr == AW'(e))      mem[e] <= wr_data;
    end
  end

  assign rd_data = mem[rd_addr];

endmodule

// File: rtl/gclut_out_stage.sv
module gclut_out_stage #(
  parameter int unsigned DW = 30
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          blank,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  logic          vld_q;
  logic [DW-1:0] dat_q;

  assign in_ready = !vld_q || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      dat_q <= '0;
    end else if (in_ready) begin
      vld_q <= in_valid;
      if (in_valid) dat_q <= blank ? '0 : in_data;
    end
  end

  assign out_valid = vld_q;
  assign out_data  = dat_q;

endmodule

// File: rtl/gclut_pixel_map.sv
module gclut_pixel_map #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned Y_W    = 8,
  parameter int unsigned C_W    = 8,
  parameter int unsigned T_W    = 6,
  localparam int unsigned ENTRY_W = Y_W + 2 * C_W + T_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [CODE_W-1:0]  pix_code,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [Y_W-1:0]     out_y,
  output logic [C_W-1:0]     out_u,
  output logic [C_W-1:0]     out_v,
  output logic [T_W-1:0]     out_t,
  input  logic               cfg_wr_req,
  output logic               cfg_wr_ack,
  input  logic [2:0]         cfg_sel,
  input  logic [CODE_W-1:0]  cfg_addr,
  input  logic [ENTRY_W-1:0] cfg_wdata
);
  logic               pix_fire;
  logic               pal_we, tab_a_we, tab_b_we, tab_c_we, mode_we;
  logic [CODE_W-1:0]  wr_addr;
  logic [ENTRY_W-1:0] wr_data;
  logic [CODE_W-1:0]  clut_idx;
  logic               no_map;
  logic [ENTRY_W-1:0] entry;
  logic [ENTRY_W-1:0] word_q;

  assign pix_fire = pix_valid && pix_ready;

  gclut_cfg_gate #(.AW(CODE_W), .DW(ENTRY_W)) u_gate (
    .cfg_wr_req (cfg_wr_req),
    .pix_fire   (pix_fire),
    .cfg_sel    (cfg_sel),
    .cfg_addr   (cfg_addr),
    .cfg_wdata  (cfg_wdata),
    .cfg_wr_ack (cfg_wr_ack),
    .pal_we     (pal_we),
    .tab_a_we   (tab_a_we),
    .tab_b_we   (tab_b_we),
    .tab_c_we   (tab_c_we),
    .mode_we    (mode_we),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data)
  );

  gclut_remap #(.CODE_W(CODE_W), .DW(ENTRY_W)) u_remap (
    .clk      (clk),
    .rst_n    (rst_n),
    .tab_a_we (tab_a_we),
    .tab_b_we (tab_b_we),
    .tab_c_we (tab_c_we),
    .mode_we  (mode_we),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pix_code (pix_code),
    .clut_idx (clut_idx),
    .no_map   (no_map)
  );

  gclut_palette #(.AW(CODE_W), .DW(ENTRY_W)) u_pal (
    .clk     (clk),
    .rst_n   (rst_n),
    .we      (pal_we),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .rd_addr (clut_idx),
    .rd_data (entry)
  );

  gclut_out_stage #(.DW(ENTRY_W)) u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (pix_valid),
    .in_ready  (pix_ready),
    .blank     (no_map),
    .in_data   (entry),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (word_q)
  );

  assign out_y = word_q[ENTRY_W-1 -: Y_W];
  assign out_u = word_q[ENTRY_W-Y_W-1 -: C_W];
  assign out_v = word_q[T_W+C_W-1 -: C_W];
  assign out_t = word_q[T_W-1:0];

endmodule

// File: rtl/gclut_pixel_map_chk.sv
module gclut_pixel_map_chk #(
  parameter int unsigned CODE_W = 8,
  parameter int unsigned Y_W    = 8,
  parameter int unsigned C_W    = 8,
  parameter int unsigned T_W    = 6
) (
  input logic           clk,
  input logic           rst_n,
  input logic           pix_valid,
  input logic           pix_ready,
  input logic           out_valid,
  input logic           out_ready,
  input logic [Y_W-1:0] out_y,
  input logic [C_W-1:0] out_u,
  input logic [C_W-1:0] out_v,
  input logic [T_W-1:0] out_t,
  input logic           cfg_wr_req,
  input logic           cfg_wr_ack
);
  // R7
  accept_to_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> out_valid);

  // R8
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable({out_y, out_u, out_v, out_t})));

  // R8
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !pix_ready);

  // R9
  no_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_ack |-> (cfg_wr_req && !(pix_valid && pix_ready)));

  // R9
  idle_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr_req && !pix_valid) |-> cfg_wr_ack);

endmodule

bind gclut_pixel_map gclut_pixel_map_chk #(
  .CODE_W(CODE_W), .Y_W(Y_W), .C_W(C_W), .T_W(T_W)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_y      (out_y),
  .out_u      (out_u),
  .out_v      (out_v),
  .out_t      (out_t),
  .cfg_wr_req (cfg_wr_req),
  .cfg_wr_ack (cfg_wr_ack)
);

// File: tb/gclut_pixel_map_tb_top.sv
module gclut_pixel_map_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pix_valid = 1'b0;
  logic        pix_ready;
  logic [7:0]  pix_code = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [7:0]  out_y, out_u, out_v;
  logic [5:0]  out_t;
  logic        cfg_wr_req = 1'b0;
  logic        cfg_wr_ack;
  logic [2:0]  cfg_sel = '0;
  logic [7:0]  cfg_addr = '0;
  logic [29:0] cfg_wdata = '0;

  always #5 clk = ~clk;

  gclut_pixel_map dut_i (
    .clk(clk), .rst_n(rst_n),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_code(pix_code),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_y(out_y), .out_u(out_u), .out_v(out_v), .out_t(out_t),
    .cfg_wr_req(cfg_wr_req), .cfg_wr_ack(cfg_wr_ack),
    .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // Model of the tables, built from the requirements.
  logic [29:0] m_pal [256];
  logic [3:0]  m_ta  [4];
  logic [7:0]  m_tb  [4];
  logic [7:0]  m_tc  [16];
  logic [2:0]  m_mode = 3'd0;

  logic [29:0] sb_q [$];
  logic [29:0] sb_tag [$];

  logic bp_en = 1'b0;
  logic hold_off = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready = hold_off ? 1'b0 : (bp_en ? lfsr[0] : 1'b1);
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [29:0] expect_of(input logic [7:0] code);
    case (m_mode)
      3'd0: return m_pal[code];
      3'd1: return m_pal[{4'b0, m_ta[code[1:0]]}];
      3'd2: return m_pal[m_tb[code[1:0]]];
      3'd3: return m_pal[m_tc[code[3:0]]];
      default: return 30'd0;
    endcase
  endfunction

  function automatic logic [29:0] pal_pat(input int i);
    logic [7:0] b;
    b = 8'(i);
    return {b ^ 8'h5A, b + 8'd3, ~b, b[5:0] ^ 6'h15};
  endfunction

  // Monitor: compare each transferred output word with the scoreboard.
  always @(negedge clk) begin
    #2;
    if (rst_n && out_valid && out_ready) begin
      if (sb_q.size() == 0) begin
        check("R8 unexpected output", {2'b0, out_y, out_u, out_v, out_t}, 32'hFFFFFFFF);
      end else begin
        logic [29:0] e;
        logic [29:0] tag;
        e = sb_q.pop_front();
        tag = sb_tag.pop_front();
        n_tests++;
        if ({out_y, out_u, out_v, out_t} !== e) begin
          n_fail++;
          $display("FAIL R%0s output (code/mode %h): actual %h expected %h",
                   "2-R6", tag, {out_y, out_u, out_v, out_t}, e);
        end
      end
    end
  end

  task automatic send_pix(input logic [7:0] code);
    @(negedge clk);
    pix_valid = 1'b1;
    pix_code  = code;
    forever begin
      #1;
      if (pix_ready) break;
      @(negedge clk);
    end
    sb_q.push_back(expect_of(code));
    sb_tag.push_back({19'd0, m_mode, code});
    @(posedge clk);
    #1;
    pix_valid = 1'b0;
  endtask

  task automatic cfg_write(input logic [2:0] sel, input logic [7:0] addr, input logic [29:0] data);
    @(negedge clk);
    cfg_wr_req = 1'b1;
    cfg_sel = sel; cfg_addr = addr; cfg_wdata = data;
    forever begin
      #1;
      if (cfg_wr_ack) break;
      @(negedge clk);
    end
    case (sel)
      3'd0: m_pal[addr] = data;
      3'd1: m_ta[addr[1:0]] = data[3:0];
      3'd2: m_tb[addr[1:0]] = data[7:0];
      3'd3: m_tc[addr[3:0]] = data[7:0];
      3'd4: m_mode = data[2:0];
      default: ;
    endcase
    @(posedge clk);
    #1;
    cfg_wr_req = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while ((sb_q.size() != 0) && (guard < 2000)) begin
      @(negedge clk);
      guard++;
    end
  endtask

  initial begin
    int k;
    for (int i = 0; i < 256; i++) m_pal[i] = '0;
    for (int i = 0; i < 4; i++) begin m_ta[i] = '0; m_tb[i] = '0; end
    for (int i = 0; i < 16; i++) m_tc[i] = '0;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    check("R1 out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 pix_ready", {31'd0, pix_ready}, 32'd1);
    check("R1 cfg_wr_ack", {31'd0, cfg_wr_ack}, 32'd0);
    // R1 tables read zero in default direct mode
    send_pix(8'h37);
    send_pix(8'hFF);
    drain();

    // R11 bulk reload: one CLUT entry per clock while pixels are idle
    k = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk);
      cfg_wr_req = 1'b1; cfg_sel = 3'd0; cfg_addr = 8'(i); cfg_wdata = pal_pat(i);
      #1;
      if (cfg_wr_ack) k++;
      m_pal[i] = pal_pat(i);
    end
    @(posedge clk); #1;
    cfg_wr_req = 1'b0;
    check("R11 back-to-back acks", k, 256);

    // R2 direct mode
    send_pix(8'h00); send_pix(8'h01); send_pix(8'h80); send_pix(8'hFF); send_pix(8'h5C);
    drain();

    // R7 latency: output valid right after the accepting edge
    send_pix(8'h42);
    check("R7 out_valid after accept", {31'd0, out_valid}, 32'd1);
    drain();

    // R3 narrow 2-bit table into CLUT 0..15
    cfg_write(3'd1, 8'd0, 30'h3FFFFFF5);
    cfg_write(3'd1, 8'd1, 30'd15);
    cfg_write(3'd1, 8'd2, 30'd0);
    cfg_write(3'd1, 8'd3, 30'd9);
    cfg_write(3'd4, 8'd0, 30'd1);
    send_pix(8'hFC); send_pix(8'h01); send_pix(8'hAE); send_pix(8'h57);
    drain();

    // R4 wide 2-bit table
    cfg_write(3'd2, 8'd0, 30'd200);
    cfg_write(3'd2, 8'd1, 30'd17);
    cfg_write(3'd2, 8'd2, 30'd255);
    cfg_write(3'd2, 8'hFF, 30'd99);
    cfg_write(3'd4, 8'd0, 30'd2);
    send_pix(8'h00); send_pix(8'hF1); send_pix(8'h06); send_pix(8'h7B);
    drain();

    // R5 4-bit table
    for (int i = 0; i < 16; i++) cfg_write(3'd3, 8'(i), 30'(8'(i * 13 + 20)));
    cfg_write(3'd4, 8'd0, 30'd3);
    send_pix(8'h00); send_pix(8'hFF); send_pix(8'hA7); send_pix(8'h3C); send_pix(8'h18);
    drain();

    // R6 modes without mapping give zeros
    cfg_write(3'd4, 8'd0, 30'd4);
    send_pix(8'h10); send_pix(8'hFF);
    cfg_write(3'd4, 8'd0, 30'd7);
    send_pix(8'h33);
    drain();

    // R10 unused select changes nothing
    cfg_write(3'd4, 8'd0, 30'd0);
    cfg_write(3'd5, 8'd0, 30'h0ABCDEF);
    cfg_write(3'd7, 8'h10, 30'h1234567);
    send_pix(8'h00); send_pix(8'h10);
    drain();

    // R8 long stall holds the output
    @(negedge clk); hold_off = 1'b1;
    send_pix(8'h66);
    @(negedge clk); #2;
    begin
      logic [29:0] held;
      held = {out_y, out_u, out_v, out_t};
      check("R8 stalled word", held, m_pal[8'h66]);
      repeat (3) @(negedge clk);
      #2;
      check("R8 held stable", {out_y, out_u, out_v, out_t}, held);
      check("R8 out_valid kept", {31'd0, out_valid}, 32'd1);
      check("R8 pix_ready low in stall", {31'd0, pix_ready}, 32'd0);
    end

    // R9 write request waits while pixels stream
    @(negedge clk); hold_off = 1'b0;
    drain();
    fork
      begin
        for (int i = 0; i < 6; i++) send_pix(8'(i + 3));
      end
      begin
        @(negedge clk); @(negedge clk);
        cfg_wr_req = 1'b1; cfg_sel = 3'd3; cfg_addr = 8'd2; cfg_wdata = 30'd77;
        #1;
        check("R9 no ack during handshake", {31'd0, cfg_wr_ack}, 32'd0);
      end
    join
    @(negedge clk); #1;
    check("R9 ack once stream idle", {31'd0, cfg_wr_ack}, 32'd1);
    m_tc[2] = 8'd77;
    @(posedge clk); #1;
    cfg_wr_req = 1'b0;
    drain();
    cfg_write(3'd4, 8'd0, 30'd3);
    send_pix(8'hF2);
    drain();

    // R8 random back-pressure over several modes
    bp_en = 1'b1;
    for (int i = 0; i < 60; i++) begin
      if (i == 20) cfg_write(3'd4, 8'd0, 30'd0);
      if (i == 40) cfg_write(3'd4, 8'd0, 30'd2);
      send_pix(8'(i * 37 + 11));
    end
    drain();
    bp_en = 1'b0;
    check("R8 scoreboard empty", sb_q.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule